// File: doc/BRIEF.md
# Four-Layer Pixel Blend and Raster-Op Compositor

This block merges up to four pixel streams of one common 32-bit format (alpha in bits 31:24, then three 8-bit colour channels) with an internally generated background layer, producing one output stream. All four input pixels for one output position arrive together on a single valid/ready handshake in raster order. A position counter tracks where in the frame each pixel lies, so the background layer can be placed as a coloured rectangle anywhere in the frame.

Four cascaded stages, A to D, each combine a destination operand with a source operand. Stage A's destination is routed by a selector. Each later stage takes the previous stage's result as its destination. A stage either alpha-blends its operands with programmable weight factors, or applies a 4-bit logical raster operation, with separate codes for colour and alpha. Stage B's source always comes from a standalone raster-op unit. That unit combines stage A's result, as its source, with a routed destination. Configuration arrives on a flat word-write port.

Top module: `layer_compositor`

## Requirements
- R1: After reset, no output is valid and the input is ready. Stage A then blends over a background covering the whole frame in opaque black (0xFF000000). All layers are disabled, so every output pixel is 0xFF000000. The frame is 8190x8190 and all stages use source-over blending.
- R2: A 3-bit selector code 0..3 picks compositor input 0..3, code 4 picks the background pixel, and codes 5..7 give an all-zero pixel. Stage A's destination is selected through the word at address 8, bits 22:20. The sources of stages A, C and D come from bits 18:16 of addresses 8, 10 and 11, and default to inputs 0, 2 and 3. Stages B to D take the previous stage's result as destination.
- R3: Stage B's source is always the raster-op unit output. Its source field (address 9, bits 18:16) is forced to zero and has no effect.
- R4: The raster-op unit (address 4) takes its source from stage A's result. Its destination comes from a selector in bits 22:20, which defaults to input 1. Its colour op code is in bits 7:4 and its alpha op code in bits 3:0, and both default to NOP.
- R5: Stage control bit 31 set means blend. Each channel result is round((D*X + S*Y)/255), saturated at 255. The X and Y factors come from address 12+n: colour X in bits 30:28, colour Y in 26:24, alpha X in 22:20, alpha Y in 18:16, coefficient X in 15:8 and coefficient Y in 7:0. Factor codes: 0 destination alpha, 1 255 minus destination alpha, 2 source alpha, 3 255 minus source alpha, 4 coefficient. The default is 3, 2, 3, 4 with coefficient Y = 255.
- R6: With bit 31 clear, a stage applies the colour code (bits 7:4) to bits 23:0 and the alpha code (bits 3:0) to bits 31:24. The codes are: 0 D, 1 S&D, 2 S&~D, 3 S, 4 ~S&D, 5 zeros, 6 S^D, 7 S|D, 8 ~(S|D), 9 ~(S^D), 10 ~D, 11 S|~D, 12 ~S, 13 ~S|D, 14 ~(S&D), 15 ones.
- R7: A stage in raster-op mode with both codes NOP outputs its destination unchanged, whatever the source pixel is.
- R8: Bits 3:0 of address 5 enable inputs 0..3. A disabled input acts as an all-zero (transparent) pixel.
- R9: The background pixel is the colour word at address 3 (A 31:24, R/Cr 23:16, G/Y 15:8, B/Cb 7:0). It applies when the position lies inside the rectangle given by size (address 1) and location (address 2), each with width or x in bits 28:16 and height or y in bits 12:0. Outside the rectangle the background pixel is zero.
- R10: The frame size at address 0 (width 28:16, height 12:0) is clamped to 4..8190 and restarts the position at (0,0). The end-of-line flag marks the last column and the end-of-frame flag marks the last pixel of the frame.
- R11: An accepted pixel appears on the output one cycle later. While the output is valid and not taken, it holds stable and the input is not ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 4 | Configuration word address |
| cfg_wdata_i | input | 32 | Configuration write data |
| in_valid_i | input | 1 | All four input pixels valid |
| in_ready_o | output | 1 | Input accepted this cycle when valid |
| in_pix_i | input | 128 | Input pixels, input n in bits 32n+31:32n |
| out_valid_o | output | 1 | Output pixel valid |
| out_ready_i | input | 1 | Downstream accepts output |
| out_pix_o | output | 32 | Composited pixel |
| out_eol_o | output | 1 | Output pixel is last in its line |
| out_eof_o | output | 1 | Output pixel is last in the frame |

## Verification
The hardest cases to reach are the ones that depend on frame position and on the separate raster-op path. A background rectangle edge only shows up at particular coordinates, so the bench shrinks the frame to 8x4 and streams a whole frame, checking every pixel and the end-of-frame flag. The path through stage B's fixed source is proved by giving inputs 1 and 2 distinguishable pixels after writing a nonzero stage B source field. The raster-op unit is then pointed at the background so that the inverted stage A result reaches the output.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int PIX_W   = 32;
  localparam int CH_W    = 8;
  localparam int NUM_CH  = PIX_W / CH_W;
  localparam int COL_W   = PIX_W - CH_W;
  localparam int NUM_IN  = 4;
  localparam int NUM_STG = 4;
  localparam int SEL_W   = 3;
  localparam int NUM_SEL = 1 << SEL_W;
  localparam int OP_W    = 4;
  localparam int DIM_W   = 13;
  localparam int ADDR_W  = 4;
  localparam int DIM_MIN = 4;
  localparam int DIM_MAX = 8190;

  localparam int A_FRAME = 0;
  localparam int A_BGSZ  = 1;
  localparam int A_BGLOC = 2;
  localparam int A_BGCOL = 3;
  localparam int A_ROPU  = 4;
  localparam int A_EN    = 5;
  localparam int A_CTRL  = 8;
  localparam int A_BLD   = 12;

  localparam logic [SEL_W-1:0] SEL_BG = 3'd4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP, OP_AND, OP_ANDR, OP_COPY, OP_ANDI, OP_CLR, OP_XOR, OP_OR,
    OP_NOR, OP_EQV, OP_INV, OP_ORR, OP_CPYI, OP_ORI, OP_NAND, OP_SET
  } rop_op_e;

  typedef enum logic [2:0] {
    F_DA, F_DA_INV, F_SA, F_SA_INV, F_COEF
  } fac_e;

  typedef struct packed {
    logic             blend_en;
    logic [SEL_W-1:0] dst_sel;
    logic [SEL_W-1:0] src_sel;
    logic [OP_W-1:0]  col_op;
    logic [OP_W-1:0]  alp_op;
  } stage_ctrl_t;

  typedef struct packed {
    logic [2:0]      cx;
    logic [2:0]      cy;
    logic [2:0]      ax;
    logic [2:0]      ay;
    logic [CH_W-1:0] coefx;
    logic [CH_W-1:0] coefy;
  } blend_cfg_t;

  function automatic logic [DIM_W-1:0] clamp_dim(logic [DIM_W-1:0] v);
    if (v < DIM_W'(DIM_MIN)) return DIM_W'(DIM_MIN);
    if (v > DIM_W'(DIM_MAX)) return DIM_W'(DIM_MAX);
    return v;
  endfunction
endpackage

// File: rtl/cmp_rop.sv
module cmp_rop
  import cmp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    src_i,
  input  logic [W-1:0]    dst_i,
  output logic [W-1:0]    res_o
);
  always_comb begin
    unique case (rop_op_e'(op_i))
      OP_NOP:  res_o = dst_i;
      OP_AND:  res_o = src_i & dst_i;
      OP_ANDR: res_o = src_i & ~dst_i;
      OP_COPY: res_o = src_i;
      OP_ANDI: res_o = ~src_i & dst_i;
      OP_CLR:  res_o = '0;
      OP_XOR:  res_o = src_i ^ dst_i;
      OP_OR:   res_o = src_i | dst_i;
      OP_NOR:  res_o = ~(src_i | dst_i);
      OP_EQV:  res_o = ~(src_i ^ dst_i);
      OP_INV:  res_o = ~dst_i;
      OP_ORR:  res_o = src_i | ~dst_i;
      OP_CPYI: res_o = ~src_i;
      OP_ORI:  res_o = ~src_i | dst_i;
      OP_NAND: res_o = ~(src_i & dst_i);
      default: res_o = '1;
    endcase
  end
endmodule

// File: rtl/cmp_stage.sv
module cmp_stage
  import cmp_pkg::*;
(
  input  stage_ctrl_t      ctrl_i,
  input  blend_cfg_t       bld_i,
  input  logic [PIX_W-1:0] dst_i,
  input  logic [PIX_W-1:0] src_i,
  output logic [PIX_W-1:0] res_o
);
  localparam int PW = 2 * CH_W + 1;
  localparam logic [PW-1:0] FULL = PW'((1 << CH_W) - 1);

  logic [CH_W-1:0]  da, sa;
  logic [PIX_W-1:0] blend_res;
  logic [COL_W-1:0] col_res;
  logic [CH_W-1:0]  alp_res;

  assign da = dst_i[PIX_W-1 -: CH_W];
  assign sa = src_i[PIX_W-1 -: CH_W];

  function automatic logic [CH_W-1:0] pick(logic [2:0] c, logic [CH_W-1:0] d_a,
                                            logic [CH_W-1:0] s_a, logic [CH_W-1:0] k);
    case (fac_e'(c))
      F_DA:     return d_a;
      F_DA_INV: return ~d_a;
      F_SA:     return s_a;
      F_SA_INV: return ~s_a;
      F_COEF:   return k;
      default:  return '0;
    endcase
  endfunction

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam bit IS_A = (ch == NUM_CH - 1);
    logic [CH_W-1:0] fx, fy, r;
    logic [PW-1:0]   sum, q;
    always_comb begin
      fx  = pick(IS_A ? bld_i.ax : bld_i.cx, da, sa, bld_i.coefx);
      fy  = pick(IS_A ? bld_i.ay : bld_i.cy, da, sa, bld_i.coefy);
      sum = PW'(dst_i[ch*CH_W +: CH_W]) * PW'(fx) + PW'(src_i[ch*CH_W +: CH_W]) * PW'(fy);
      q   = (sum + (FULL >> 1)) / FULL;
      r   = (q > FULL) ? '1 : q[CH_W-1:0];
    end
    assign blend_res[ch*CH_W +: CH_W] = r;
  end

  cmp_rop #(.W(COL_W)) u_rop_col (
    .op_i(ctrl_i.col_op), .src_i(src_i[COL_W-1:0]), .dst_i(dst_i[COL_W-1:0]), .res_o(col_res)
  );
  cmp_rop #(.W(CH_W)) u_rop_alp (
    .op_i(ctrl_i.alp_op), .src_i(sa), .dst_i(da), .res_o(alp_res)
  );

  assign res_o = ctrl_i.blend_en ? blend_res : {alp_res, col_res};
endmodule

// File: rtl/cmp_cfg.sv
module cmp_cfg
  import cmp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PIX_W-1:0]  wdata_i,
  output logic              frame_wr_o,
  output logic [DIM_W-1:0]  frame_w_o,
  output logic [DIM_W-1:0]  frame_h_o,
  output logic [DIM_W-1:0]  bg_w_o,
  output logic [DIM_W-1:0]  bg_h_o,
  output logic [DIM_W-1:0]  bg_x_o,
  output logic [DIM_W-1:0]  bg_y_o,
  output logic [PIX_W-1:0]  bg_col_o,
  output stage_ctrl_t       ropu_o,
  output logic [NUM_IN-1:0] en_o,
  output stage_ctrl_t       ctrl_o [NUM_STG],
  output blend_cfg_t        bld_o  [NUM_STG]
);
  localparam blend_cfg_t BLD_RST = '{cx: 3'(F_SA_INV), cy: 3'(F_SA), ax: 3'(F_SA_INV),
                                     ay: 3'(F_COEF), coefx: '0, coefy: '1};

  assign frame_wr_o = we_i && (addr_i == ADDR_W'(A_FRAME));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_w_o <= DIM_W'(DIM_MAX);
      frame_h_o <= DIM_W'(DIM_MAX);
      bg_w_o    <= '1;
      bg_h_o    <= '1;
      bg_x_o    <= '0;
      bg_y_o    <= '0;
      bg_col_o  <= {{CH_W{1'b1}}, {COL_W{1'b0}}};
      ropu_o    <= '{blend_en: 1'b0, dst_sel: 3'd1, src_sel: '0, col_op: OP_NOP, alp_op: OP_NOP};
      en_o      <= '0;
      for (int k = 0; k < NUM_STG; k++) begin
        ctrl_o[k] <= '{blend_en: 1'b1, dst_sel: (k == 0) ? SEL_BG : '0,
                       src_sel: (k == 1) ? '0 : SEL_W'(k), col_op: OP_NOP, alp_op: OP_NOP};
        bld_o[k]  <= BLD_RST;
      end
    end else if (we_i) begin
      case (int'(addr_i))
        A_FRAME: begin
          frame_w_o <= clamp_dim(wdata_i[16 +: DIM_W]);
          frame_h_o <= clamp_dim(wdata_i[0 +: DIM_W]);
        end
        A_BGSZ: begin
          bg_w_o <= wdata_i[16 +: DIM_W];
          bg_h_o <= wdata_i[0 +: DIM_W];
        end
        A_BGLOC: begin
          bg_x_o <= wdata_i[16 +: DIM_W];
          bg_y_o <= wdata_i[0 +: DIM_W];
        end
        A_BGCOL: bg_col_o <= wdata_i;
        A_ROPU:  ropu_o <= '{blend_en: 1'b0, dst_sel: wdata_i[22:20], src_sel: '0,
                             col_op: wdata_i[7:4], alp_op: wdata_i[3:0]};
        A_EN:    en_o <= wdata_i[NUM_IN-1:0];
        default: ;
      endcase
      for (int k = 0; k < NUM_STG; k++) begin
        if (addr_i == ADDR_W'(A_CTRL + k))
          ctrl_o[k] <= '{blend_en: wdata_i[31], dst_sel: wdata_i[22:20],
                         src_sel: (k == 1) ? '0 : wdata_i[18:16],
                         col_op: wdata_i[7:4], alp_op: wdata_i[3:0]};
        if (addr_i == ADDR_W'(A_BLD + k))
          bld_o[k] <= '{cx: wdata_i[30:28], cy: wdata_i[26:24], ax: wdata_i[22:20],
                        ay: wdata_i[18:16], coefx: wdata_i[15:8], coefy: wdata_i[7:0]};
      end
    end
  end
endmodule

// File: rtl/cmp_bg.sv
module cmp_bg
  import cmp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             advance_i,
  input  logic [DIM_W-1:0] frame_w_i,
  input  logic [DIM_W-1:0] frame_h_i,
  input  logic [DIM_W-1:0] bg_w_i,
  input  logic [DIM_W-1:0] bg_h_i,
  input  logic [DIM_W-1:0] bg_x_i,
  input  logic [DIM_W-1:0] bg_y_i,
  input  logic [PIX_W-1:0] bg_col_i,
  output logic [PIX_W-1:0] bg_pix_o,
  output logic             eol_o,
  output logic             eof_o
);
  logic [DIM_W-1:0] x_q, y_q;
  logic             in_x, in_y;

  assign eol_o = (x_q == frame_w_i - 1'b1);
  assign eof_o = eol_o && (y_q == frame_h_i - 1'b1);

  assign in_x = ({1'b0, x_q} >= {1'b0, bg_x_i}) && ({1'b0, x_q} < {1'b0, bg_x_i} + {1'b0, bg_w_i});
  assign in_y = ({1'b0, y_q} >= {1'b0, bg_y_i}) && ({1'b0, y_q} < {1'b0, bg_y_i} + {1'b0, bg_h_i});
  assign bg_pix_o = (in_x && in_y) ? bg_col_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q <= '0;
      y_q <= '0;
    end else if (restart_i) begin
      x_q <= '0;
      y_q <= '0;
    end else if (advance_i) begin
      if (eol_o) begin
        x_q <= '0;
        y_q <= eof_o ? '0 : y_q + 1'b1;
      end else begin
        x_q <= x_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/layer_compositor.sv
module layer_compositor
  import cmp_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_we_i,
  input  logic [ADDR_W-1:0]       cfg_addr_i,
  input  logic [PIX_W-1:0]        cfg_wdata_i,
  input  logic                    in_valid_i,
  output logic                    in_ready_o,
  input  logic [NUM_IN*PIX_W-1:0] in_pix_i,
  output logic                    out_valid_o,
  input  logic                    out_ready_i,
  output logic [PIX_W-1:0]        out_pix_o,
  output logic                    out_eol_o,
  output logic                    out_eof_o
);
  logic             frame_wr;
  logic [DIM_W-1:0] frame_w, frame_h, bg_w, bg_h, bg_x, bg_y;
  logic [PIX_W-1:0] bg_col, bg_pix;
  stage_ctrl_t      ropu;
  logic [NUM_IN-1:0] en;
  stage_ctrl_t      ctrl [NUM_STG];
  blend_cfg_t       bld  [NUM_STG];
  logic             eol, eof, accept;
  logic [PIX_W-1:0] cand    [NUM_SEL];
  logic [PIX_W-1:0] stg_res [NUM_STG];
  logic [PIX_W-1:0] ropu_dst, ropu_res;

  cmp_cfg u_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .frame_wr_o(frame_wr), .frame_w_o(frame_w), .frame_h_o(frame_h),
    .bg_w_o(bg_w), .bg_h_o(bg_h), .bg_x_o(bg_x), .bg_y_o(bg_y), .bg_col_o(bg_col),
    .ropu_o(ropu), .en_o(en), .ctrl_o(ctrl), .bld_o(bld)
  );

  assign in_ready_o = !out_valid_o || out_ready_i;
  assign accept     = in_valid_i && in_ready_o;

  cmp_bg u_bg (
    .clk_i, .rst_ni, .restart_i(frame_wr), .advance_i(accept),
    .frame_w_i(frame_w), .frame_h_i(frame_h), .bg_w_i(bg_w), .bg_h_i(bg_h),
    .bg_x_i(bg_x), .bg_y_i(bg_y), .bg_col_i(bg_col),
    .bg_pix_o(bg_pix), .eol_o(eol), .eof_o(eof)
  );

  // selector candidates: inputs (masked), background, then zero
  for (genvar i = 0; i < NUM_SEL; i++) begin : g_cand
    if (i < NUM_IN) begin : g_in
      assign cand[i] = en[i] ? in_pix_i[i*PIX_W +: PIX_W] : '0;
    end else if (i == int'(SEL_BG)) begin : g_bg
      assign cand[i] = bg_pix;
    end else begin : g_zero
      assign cand[i] = '0;
    end
  end

  assign ropu_dst = cand[ropu.dst_sel];
  cmp_rop #(.W(COL_W)) u_ropu_col (
    .op_i(ropu.col_op), .src_i(stg_res[0][COL_W-1:0]), .dst_i(ropu_dst[COL_W-1:0]),
    .res_o(ropu_res[COL_W-1:0])
  );
  cmp_rop #(.W(CH_W)) u_ropu_alp (
    .op_i(ropu.alp_op), .src_i(stg_res[0][PIX_W-1 -: CH_W]), .dst_i(ropu_dst[PIX_W-1 -: CH_W]),
    .res_o(ropu_res[PIX_W-1 -: CH_W])
  );

  for (genvar k = 0; k < NUM_STG; k++) begin : g_stg
    logic [PIX_W-1:0] d, s;
    if (k == 0) begin : g_dsel
      assign d = cand[ctrl[0].dst_sel];
    end else begin : g_dchain
      assign d = stg_res[k-1];
    end
    if (k == 1) begin : g_sropu
      assign s = ropu_res;
    end else begin : g_ssel
      assign s = cand[ctrl[k].src_sel];
    end
    cmp_stage u_stage (.ctrl_i(ctrl[k]), .bld_i(bld[k]), .dst_i(d), .src_i(s), .res_o(stg_res[k]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_pix_o   <= '0;
      out_eol_o   <= 1'b0;
      out_eof_o   <= 1'b0;
    end else if (in_ready_o) begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        out_pix_o <= stg_res[NUM_STG-1];
        out_eol_o <= eol;
        out_eof_o <= eof;
      end
    end
  end
endmodule

// File: rtl/cmp_checker.sv
module cmp_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_valid_i,
  input logic        in_ready_o,
  input logic        out_valid_o,
  input logic        out_ready_i,
  input logic [31:0] out_pix_o,
  input logic        out_eol_o,
  input logic        out_eof_o
);
  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_pix_o) && $stable(out_eol_o) && $stable(out_eof_o));

  assert_accept_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> out_valid_o);

  assert_drain_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && !in_valid_i |=> !out_valid_o);

  assert_idle_ready_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> in_ready_o);

  assert_eof_eol_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_eof_o |-> out_eol_o);
endmodule

bind layer_compositor cmp_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
  .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_pix_o(out_pix_o),
  .out_eol_o(out_eol_o), .out_eof_o(out_eof_o)
);

// File: tb/layer_compositor_bench.sv
`timescale 1ns/1ps
module layer_compositor_bench;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         cfg_we = 1'b0;
  logic [3:0]   cfg_addr = '0;
  logic [31:0]  cfg_wdata = '0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_pix = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [31:0]  out_pix;
  logic         out_eol, out_eof;

  always #4 clk = ~clk;

  layer_compositor u_layer_compositor (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_pix_i(in_pix),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_pix_o(out_pix),
    .out_eol_o(out_eol), .out_eof_o(out_eof)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // shadow configuration and position
  int fw = 8190, fh = 8190, bgw = 8191, bgh = 8191, bgx = 0, bgy = 0;
  logic [31:0] bgc = 32'hFF00_0000;
  logic [31:0] srop = 32'h0010_0000;
  logic [3:0]  sen = '0;
  logic [31:0] sctrl [4] = '{32'h8040_0000, 32'h8000_0000, 32'h8002_0000, 32'h8003_0000};
  logic [31:0] sbld  [4] = '{32'h3234_00FF, 32'h3234_00FF, 32'h3234_00FF, 32'h3234_00FF};
  int px = 0, py = 0;
  logic [31:0] ip [4];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int clampd(int v);
    if (v < 4) return 4;
    if (v > 8190) return 8190;
    return v;
  endfunction

  function automatic logic [7:0] fac(logic [2:0] c, logic [7:0] da, logic [7:0] sa, logic [7:0] k);
    case (c)
      3'd0: return da;
      3'd1: return 8'd255 - da;
      3'd2: return sa;
      3'd3: return 8'd255 - sa;
      3'd4: return k;
      default: return 8'd0;
    endcase
  endfunction

  function automatic logic [7:0] mix(logic [7:0] d, logic [7:0] s, logic [7:0] fx, logic [7:0] fy);
    int t;
    t = (int'(d) * int'(fx) + int'(s) * int'(fy) + 127) / 255;
    return (t > 255) ? 8'hFF : 8'(t);
  endfunction

  function automatic logic [31:0] lop(logic [3:0] op, logic [31:0] s, logic [31:0] d);
    case (op)
      4'd0: return d;          4'd1: return s & d;
      4'd2: return s & ~d;     4'd3: return s;
      4'd4: return ~s & d;     4'd5: return 32'h0;
      4'd6: return s ^ d;      4'd7: return s | d;
      4'd8: return ~(s | d);   4'd9: return ~(s ^ d);
      4'd10: return ~d;        4'd11: return s | ~d;
      4'd12: return ~s;        4'd13: return ~s | d;
      4'd14: return ~(s & d);  default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] split_op(logic [3:0] cop, logic [3:0] aop, logic [31:0] s, logic [31:0] d);
    logic [31:0] c, a;
    c = lop(cop, s, d);
    a = lop(aop, s, d);
    return {a[31:24], c[23:0]};
  endfunction

  function automatic logic [31:0] stage_m(logic [31:0] c, logic [31:0] b, logic [31:0] d, logic [31:0] s);
    logic [31:0] r;
    if (!c[31]) return split_op(c[7:4], c[3:0], s, d);
    for (int ch = 0; ch < 3; ch++)
      r[ch*8 +: 8] = mix(d[ch*8 +: 8], s[ch*8 +: 8],
                         fac(b[30:28], d[31:24], s[31:24], b[15:8]),
                         fac(b[26:24], d[31:24], s[31:24], b[7:0]));
    r[31:24] = mix(d[31:24], s[31:24], fac(b[22:20], d[31:24], s[31:24], b[15:8]),
                   fac(b[18:16], d[31:24], s[31:24], b[7:0]));
    return r;
  endfunction

  function automatic logic [31:0] pick_m(logic [2:0] code);
    bit inside_bg;
    if (code < 3'd4) return sen[code[1:0]] ? ip[code[1:0]] : 32'h0;
    if (code != 3'd4) return 32'h0;
    inside_bg = (px >= bgx) && (px < bgx + bgw) && (py >= bgy) && (py < bgy + bgh);
    return inside_bg ? bgc : 32'h0;
  endfunction

  function automatic logic [31:0] model();
    logic [31:0] a, r, b, c;
    a = stage_m(sctrl[0], sbld[0], pick_m(sctrl[0][22:20]), pick_m(sctrl[0][18:16]));
    r = split_op(srop[7:4], srop[3:0], a, pick_m(srop[22:20]));
    b = stage_m(sctrl[1], sbld[1], a, r);
    c = stage_m(sctrl[2], sbld[2], b, pick_m(sctrl[2][18:16]));
    return stage_m(sctrl[3], sbld[3], c, pick_m(sctrl[3][18:16]));
  endfunction

  function automatic logic [31:0] pat(int k);
    logic [31:0] v;
    v = 32'(k) * 32'h9E37_79B1;
    return v ^ (v >> 13) ^ 32'h5A5A_1234;
  endfunction

  task automatic cfg_write(int addr, logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
    case (addr)
      0: begin fw = clampd(int'(data[28:16])); fh = clampd(int'(data[12:0])); px = 0; py = 0; end
      1: begin bgw = int'(data[28:16]); bgh = int'(data[12:0]); end
      2: begin bgx = int'(data[28:16]); bgy = int'(data[12:0]); end
      3: bgc = data;
      4: srop = data;
      5: sen = data[3:0];
      8, 10, 11: sctrl[addr-8] = data;
      9: sctrl[1] = data & ~32'h0007_0000;
      12, 13, 14, 15: sbld[addr-12] = data;
      default: ;
    endcase
  endtask

  task automatic push(logic [31:0] a0, logic [31:0] a1, logic [31:0] a2, logic [31:0] a3,
                      string req, output logic [31:0] got);
    logic [31:0] exp;
    logic        e_eol, e_eof;
    @(negedge clk);
    ip[0] = a0; ip[1] = a1; ip[2] = a2; ip[3] = a3;
    in_pix = {a3, a2, a1, a0};
    in_valid = 1'b1;
    exp   = model();
    e_eol = (px == fw - 1);
    e_eof = e_eol && (py == fh - 1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, 32'(out_valid), 32'd1);
    chk({req, " pixel"}, out_pix, exp);
    chk({req, " eol"}, 32'(out_eol), 32'(e_eol));
    chk({req, " eof"}, 32'(out_eof), 32'(e_eof));
    got = out_pix;
    if (e_eol) begin px = 0; py = e_eof ? 0 : py + 1; end else px++;
  endtask

  task automatic t_defaults();
    logic [31:0] g;
    for (int k = 0; k < 3; k++) begin
      push(pat(k), pat(k + 1), pat(k + 2), pat(k + 3), "R1 default black", g);
      chk("R1 opaque black", g, 32'hFF00_0000);
    end
  endtask

  task automatic t_blend();
    logic [31:0] g;
    cfg_write(5, 32'h1);
    push(32'h80FF_0000, 32'h0, 32'h0, 32'h0, "R5 half over black", g);
    chk("R5 hand value", g, 32'hFF80_0000);
    cfg_write(5, 32'hA);
    for (int k = 0; k < 6; k++) push(pat(3*k), pat(3*k+1), pat(3*k+2), pat(3*k+7), "R8 partial enable", g);
    cfg_write(5, 32'hF);
    for (int k = 0; k < 6; k++) push(pat(5*k), pat(5*k+1), pat(5*k+2), pat(5*k+3), "R2 all layers", g);
    cfg_write(14, 32'h4444_FFFF);
    push(32'hFF80_8080, 32'h0, 32'h40C0_C0C0, 32'h0, "R5 saturation", g);
    chk("R5 saturated", g, 32'hFFFF_FFFF);
    cfg_write(14, 32'h0112_3C71);
    for (int k = 0; k < 4; k++) push(pat(k+40), pat(k+41), pat(k+42), pat(k+43), "R5 dst alpha and coef codes", g);
    cfg_write(14, 32'h3234_00FF);
  endtask

  task automatic t_routing();
    logic [31:0] g;
    cfg_write(8, 32'h8030_0000);
    for (int k = 0; k < 4; k++) push(pat(k+60), pat(k+61), pat(k+62), pat(k+63), "R2 stage A dst input 3", g);
    cfg_write(8, 32'h8040_0000);
    cfg_write(9, 32'h8002_0000);
    push(32'h0, 32'hFF00_FF00, 32'h0000_00FF, 32'h0, "R3 stage B ignores src field", g);
    chk("R3 source from raster-op unit", g, 32'hFF00_FF00);
    cfg_write(9, 32'h8000_0000);
    cfg_write(4, 32'h0040_00C3);
    for (int k = 0; k < 4; k++) push(pat(k+80), pat(k+81), pat(k+82), pat(k+83), "R4 raster-op unit", g);
    cfg_write(4, 32'h0010_0000);
  endtask

  task automatic t_rop_codes();
    logic [31:0] g, g2;
    for (int op = 0; op < 16; op++) begin
      cfg_write(11, 32'h0003_0000 | (32'(op) << 4) | 32'(op));
      push(pat(op+100), pat(op+101), pat(op+102), pat(op+103), "R6 raster-op code", g);
    end
    cfg_write(11, 32'h0003_0000);
    push(pat(7), pat(8), pat(9), 32'h1234_5678, "R7 NOP first", g);
    push(pat(7), pat(8), pat(9), 32'hEDCB_A987, "R7 NOP second", g2);
    chk("R7 source ignored", g2, g);
    cfg_write(11, 32'h8003_0000);
  endtask

  task automatic t_background();
    logic [31:0] g;
    cfg_write(5, 32'h0);
    cfg_write(0, 32'h0008_0004);
    cfg_write(1, 32'h0003_0002);
    cfg_write(2, 32'h0002_0001);
    cfg_write(3, 32'h8011_2233);
    for (int k = 0; k < 32; k++) push(pat(k), pat(k), pat(k), pat(k), "R9 background region", g);
    chk("R9 inside corner", 32'(px == 0 && py == 0), 32'd1);
  endtask

  task automatic t_clamp();
    logic [31:0] g;
    cfg_write(0, 32'h0002_1FFF);
    for (int k = 0; k < 6; k++) push(pat(k), pat(k), pat(k), pat(k), "R10 clamped width", g);
    chk("R10 width clamp to 4", 32'(fw), 32'd4);
  endtask

  task automatic t_stall();
    logic [31:0] e1, e2;
    cfg_write(5, 32'hF);
    @(negedge clk);
    ip[0] = pat(200); ip[1] = pat(201); ip[2] = pat(202); ip[3] = pat(203);
    in_pix = {ip[3], ip[2], ip[1], ip[0]};
    in_valid = 1'b1; out_ready = 1'b0;
    e1 = model();
    @(posedge clk); @(negedge clk);
    if (px == fw - 1) begin px = 0; py = (py == fh - 1) ? 0 : py + 1; end else px++;
    chk("R11 first out", out_pix, e1);
    ip[0] = pat(300); ip[1] = pat(301); ip[2] = pat(302); ip[3] = pat(303);
    in_pix = {ip[3], ip[2], ip[1], ip[0]};
    e2 = model();
    repeat (3) begin
      @(posedge clk); @(negedge clk);
      chk("R11 held pixel", out_pix, e1);
      chk("R11 not ready", 32'(in_ready), 32'd0);
    end
    out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    chk("R11 next pixel", out_pix, e2);
    chk("R11 valid", 32'(out_valid), 32'd1);
    if (px == fw - 1) begin px = 0; py = (py == fh - 1) ? 0 : py + 1; end else px++;
    @(posedge clk); @(negedge clk);
    chk("R11 drained", 32'(out_valid), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset valid", 32'(out_valid), 32'd0);
    chk("R1 reset ready", 32'(in_ready), 32'd1);
    rst_ni = 1'b1;
    t_defaults();
    t_blend();
    t_routing();
    t_rop_codes();
    t_stall();
    t_background();
    t_clamp();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule